// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller with Acknowledge

This block joins two eight-line rotating-priority interrupt resolvers into one sixteen-line controller. Request lines 0 to 7 feed the upper (master) controller and lines 8 to 15 feed the lower (slave) controller. Whenever the slave has an interrupt that it would deliver, that fact reaches the master as a one-cycle set on its cascade input, line 2, so the slave as a whole competes at line 2's priority. Requests are edge-triggered: a line has to go from low to high to become pending, and holding it high adds nothing more.

The CPU sees one request output and a resolved interrupt number from 0 to 15. When the master's winner is the cascade line, the number is 8 plus the slave's winner. A one-cycle acknowledge strobe accepts the current winner. It clears that line's pending bit and then either marks the line in service or, in automatic end-of-interrupt mode, leaves it out of service. In that mode it can also rotate the priority so that the acknowledged line becomes the lowest. For a slave interrupt, both the slave line and master line 2 are acknowledged. The acknowledge latches an 8-bit vector, built from the upper five bits of the owning controller's base with the line number below them.

A three-state machine drives the CPU request. In `ST_IDLE` the output is low, and the machine moves to `ST_RAISE` when the master has a deliverable interrupt. In `ST_RAISE` the output is high, and an acknowledge moves it to `ST_GAP`. `ST_GAP` holds the output low for one cycle and then goes back to `ST_RAISE` if the master still has a deliverable interrupt, or to `ST_IDLE` if it does not.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `irq_o` is 0 and `vector_o` is 0x00, and no line is pending or in service.
- R2: A rising edge on a master line other than 2, present at one rising clock edge, makes `irq_o` go high after the next rising clock edge, and `irq_num_o` shows that line.
- R3: Among lines that can be delivered, the winner is the one whose distance (line − rotation base) mod 8 is smallest. The rotation base is 0 after reset, and `irq_num_o` follows a newly pending line of higher priority while `irq_o` stays high.
- R4: A rising edge on slave line k (input 8+k) makes master line 2 pending one cycle later. When line 2 wins at the master, `irq_num_o` is 8+k, and acknowledging it latches the vector {slave base[7:3], k[2:0]}.
- R5: Acknowledging master line n latches the vector {master base[7:3], n[2:0]}. Bits 2:0 of either base input have no effect.
- R6: An acknowledge clears the pending bit of the acknowledged line. A request input held high after that does not make the line pending again.
- R7: With automatic end-of-interrupt off, an acknowledge puts the line in service. Lines of equal or lower priority are then blocked, and lines of higher priority still interrupt.
- R8: With automatic end-of-interrupt on, an acknowledge sets no in-service bit, so remaining lower-priority pending lines are delivered next.
- R9: With automatic end-of-interrupt and rotate-on-acknowledge both on, an acknowledge of line n sets that controller's rotation base to (n+1) mod 8.
- R10: `irq_o` is low in the cycle after an accepted acknowledge, and is high again in the cycle after that if the master still has a deliverable interrupt.
- R11: An acknowledge strobe while `irq_o` is low is ignored: the latched vector and all pending and in-service state stay unchanged.
- R12: A slave acknowledge with master automatic end-of-interrupt off puts master line 2 in service. Master lines 3 to 7 are then blocked, and lines 0 and 1 still interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 16 | Request lines; bits 7:0 master, bits 15:8 slave; bit 2 unused (cascade) |
| ack_i | input | 1 | CPU acknowledge strobe, one cycle |
| m_base_i | input | 8 | Master vector base; bits 2:0 ignored |
| s_base_i | input | 8 | Slave vector base; bits 2:0 ignored |
| m_aeoi_i | input | 1 | Master automatic end-of-interrupt |
| m_rot_i | input | 1 | Master rotate on automatic end-of-interrupt |
| s_aeoi_i | input | 1 | Slave automatic end-of-interrupt |
| s_rot_i | input | 1 | Slave rotate on automatic end-of-interrupt |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_num_o | output | 4 | Resolved interrupt number 0 to 15, valid while `irq_o` is high |
| vector_o | output | 8 | Vector latched at the last accepted acknowledge |

## Verification
Several rules are checked on every cycle by the assertions:
- `irq_o` is never high without a deliverable master interrupt.
- An acknowledge clears the pending bit, sets the in-service bit, or rotates the priority as the mode settings require.
- An ignored acknowledge leaves the vector unchanged.
- A slave acknowledge latches the slave line into the vector.

Other behaviour shows only in the bench's sequences, because it depends on what happened before:
- the exact latency through the cascade;
- which line is blocked by earlier in-service bits;
- the order in which lines are served after a rotation;
- a held request line not being served again;
- the slave's second request being passed up again after an acknowledge.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

    // Default geometry shared by the controller pieces.
    localparam int LINES_DEF   = 8;
    localparam int CASCADE_DEF = 2;
    localparam int VEC_W_DEF   = 8;

    // CPU-facing request sequencing.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAISE = 2'd1,
        ST_GAP   = 2'd2
    } cpu_state_e;

endpackage

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
    parameter int LINES = 8,
    localparam int LW   = $clog2(LINES)
) (
    input  logic [LINES-1:0] pend_i,
    input  logic [LINES-1:0] insvc_i,
    input  logic [LW-1:0]    rot_i,
    output logic             valid_o,
    output logic [LW-1:0]    line_o
);

    logic          p_found, s_found;
    logic [LW-1:0] p_rank, s_rank;

    // Rank 0 is the line at the rotation base; lower rank wins.
    always_comb begin
        p_found = 1'b0;
        s_found = 1'b0;
        p_rank  = '0;
        s_rank  = '0;
        for (int k = LINES - 1; k >= 0; k--) begin
            if (pend_i[LW'(k) + rot_i]) begin
                p_found = 1'b1;
                p_rank  = LW'(k);
            end
            if (insvc_i[LW'(k) + rot_i]) begin
                s_found = 1'b1;
                s_rank  = LW'(k);
            end
        end
    end

    assign valid_o = p_found && (!s_found || (p_rank < s_rank));
    assign line_o  = p_rank + rot_i;

endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
    parameter int LINES = 8,
    localparam int LW   = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl_i,
    input  logic [LINES-1:0] setp_i,
    input  logic             aeoi_i,
    input  logic             rot_aeoi_i,
    input  logic             ack_i,
    input  logic [LW-1:0]    ack_line_i,
    output logic             valid_o,
    output logic [LW-1:0]    line_o
);

    logic [LINES-1:0] last_q, pend_q, insvc_q;
    logic [LINES-1:0] new_edge, ack_mask;
    logic [LW-1:0]    rot_q;

    assign new_edge = lvl_i & ~last_q;
    assign ack_mask = ack_i ? (LINES'(1) << ack_line_i) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= '0;
            pend_q  <= '0;
            insvc_q <= '0;
            rot_q   <= '0;
        end else begin
            last_q <= lvl_i;
            pend_q <= (pend_q & ~ack_mask) | new_edge | setp_i;
            if (ack_i && !aeoi_i) begin
                insvc_q <= insvc_q | ack_mask;
            end
            if (ack_i && aeoi_i && rot_aeoi_i) begin
                rot_q <= ack_line_i + 1'b1;
            end
        end
    end

    irq_prio_resolver #(.LINES(LINES)) i_resolver (
        .pend_i  (pend_q),
        .insvc_i (insvc_q),
        .rot_i   (rot_q),
        .valid_o (valid_o),
        .line_o  (line_o)
    );

    // R6: acknowledged line leaves pending unless re-set in the same cycle
    a_r6_ack_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !new_edge[ack_line_i] && !setp_i[ack_line_i])
        |=> !pend_q[$past(ack_line_i)]);

    // R7: without automatic end-of-interrupt the line enters service
    a_r7_ack_sets_insvc: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !aeoi_i) |=> insvc_q[$past(ack_line_i)]);

    // R8: with automatic end-of-interrupt nothing enters service
    a_r8_aeoi_no_insvc: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && aeoi_i) |=> (insvc_q == $past(insvc_q)));

    // R9: rotation base moves to one past the acknowledged line
    a_r9_rotate_base: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && aeoi_i && rot_aeoi_i) |=> (rot_q == LW'($past(ack_line_i) + 1'b1)));

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int LINES     = LINES_DEF,
    parameter int CASC_LINE = CASCADE_DEF,
    parameter int VEC_W     = VEC_W_DEF,
    localparam int LW       = $clog2(LINES),
    localparam int TOTAL    = 2 * LINES,
    localparam int NUM_W    = LW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOTAL-1:0] req_i,
    input  logic             ack_i,
    input  logic [VEC_W-1:0] m_base_i,
    input  logic [VEC_W-1:0] s_base_i,
    input  logic             m_aeoi_i,
    input  logic             m_rot_i,
    input  logic             s_aeoi_i,
    input  logic             s_rot_i,
    output logic             irq_o,
    output logic [NUM_W-1:0] irq_num_o,
    output logic [VEC_W-1:0] vector_o
);

    localparam logic [LINES-1:0] CASC_MASK = LINES'(1) << CASC_LINE;

    cpu_state_e       state_q, state_d;
    logic             m_valid, s_valid;
    logic [LW-1:0]    m_line, s_line;
    logic             ack_fire, casc_win;
    logic [LINES-1:0] m_lvl, m_setp;
    logic [VEC_W-1:0] vec_q, vec_next;

    assign casc_win = (m_line == LW'(CASC_LINE));
    assign m_lvl    = req_i[LINES-1:0] & ~CASC_MASK;
    assign m_setp   = (s_valid && !ack_fire) ? CASC_MASK : '0;

    irq_unit #(.LINES(LINES)) i_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (req_i[TOTAL-1:LINES]),
        .setp_i     ('0),
        .aeoi_i     (s_aeoi_i),
        .rot_aeoi_i (s_rot_i),
        .ack_i      (ack_fire && casc_win),
        .ack_line_i (s_line),
        .valid_o    (s_valid),
        .line_o     (s_line)
    );

    irq_unit #(.LINES(LINES)) i_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (m_lvl),
        .setp_i     (m_setp),
        .aeoi_i     (m_aeoi_i),
        .rot_aeoi_i (m_rot_i),
        .ack_i      (ack_fire),
        .ack_line_i (m_line),
        .valid_o    (m_valid),
        .line_o     (m_line)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ack_fire) begin
                vec_q <= vec_next;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (m_valid) state_d = ST_RAISE;
            ST_RAISE: if (ack_i)   state_d = ST_GAP;
            ST_GAP:   state_d = m_valid ? ST_RAISE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_o     = (state_q == ST_RAISE);
        ack_fire  = irq_o && ack_i;
        irq_num_o = casc_win ? {1'b1, s_line} : {1'b0, m_line};
        vec_next  = casc_win ? {s_base_i[VEC_W-1:LW], s_line}
                             : {m_base_i[VEC_W-1:LW], m_line};
        vector_o  = vec_q;
    end

    // R2: CPU request only while the master has something deliverable
    a_r2_irq_needs_winner: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> m_valid);

    // R10: request drops in the cycle after an accepted acknowledge
    a_r10_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);

    // R11: a stray acknowledge leaves the vector alone
    a_r11_stray_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && ack_i) |=> $stable(vector_o));

    // R4: a slave interrupt's vector carries the slave line
    a_r4_slave_vector_line: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i && irq_num_o[LW]) |=> (vector_o[LW-1:0] == $past(irq_num_o[LW-1:0])));

endmodule

// File: tb/test_irq_cascade_ctrl.sv
`timescale 1ns/1ps
module test_irq_cascade_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic        ack = 1'b0;
    logic [7:0]  m_base = 8'h27;
    logic [7:0]  s_base = 8'h7D;
    logic        m_aeoi = 1'b0, m_rot = 1'b0, s_aeoi = 1'b0, s_rot = 1'b0;
    logic        irq;
    logic [3:0]  num;
    logic [7:0]  vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_cascade_ctrl i_irq_cascade_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .ack_i     (ack),
        .m_base_i  (m_base),
        .s_base_i  (s_base),
        .m_aeoi_i  (m_aeoi),
        .m_rot_i   (m_rot),
        .s_aeoi_i  (s_aeoi),
        .s_rot_i   (s_rot),
        .irq_o     (irq),
        .irq_num_o (num),
        .vector_o  (vec)
    );

    // cfg = {m_aeoi, m_rot, s_aeoi, s_rot}
    typedef struct packed {
        logic        rst;
        logic [3:0]  cfg;
        logic [15:0] req;
        logic        ack;
        logic        chk;
        logic        irq;
        logic [3:0]  num;
        logic        vchk;
        logic [7:0]  vec;
        logic [3:0]  tag;
    } row_t;

    localparam int NROWS = 48;
    localparam row_t TBL [NROWS] = '{
        // master path, nesting with in-service bits: R1 R2 R3 R5 R7 R10 R11
        '{1'b1, 4'h0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 4'd1},
        '{1'b0, 4'h0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h00, 4'd1},
        '{1'b0, 4'h0, 16'h0020, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h00, 4'd2},
        '{1'b0, 4'h0, 16'h0020, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd2},
        '{1'b0, 4'h0, 16'h0028, 1'b0, 1'b1, 1'b1, 4'h5, 1'b0, 8'h00, 4'd2},
        '{1'b0, 4'h0, 16'h0028, 1'b0, 1'b1, 1'b1, 4'h3, 1'b0, 8'h00, 4'd3},
        '{1'b0, 4'h0, 16'h0028, 1'b1, 1'b1, 1'b1, 4'h3, 1'b0, 8'h00, 4'd3},
        '{1'b0, 4'h0, 16'h0028, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h23, 4'd5},
        '{1'b0, 4'h0, 16'h0028, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h23, 4'd7},
        '{1'b0, 4'h0, 16'h002A, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd7},
        '{1'b0, 4'h0, 16'h002A, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd7},
        '{1'b0, 4'h0, 16'h002A, 1'b1, 1'b1, 1'b1, 4'h1, 1'b0, 8'h00, 4'd7},
        '{1'b0, 4'h0, 16'h002A, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h21, 4'd10},
        '{1'b0, 4'h0, 16'h002A, 1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 8'h21, 4'd11},
        '{1'b0, 4'h0, 16'h002A, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h21, 4'd11},
        // slave through cascade, master line 2 in service: R4 R12
        '{1'b1, 4'h0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 4'd1},
        '{1'b0, 4'h0, 16'h1000, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h00, 4'd1},
        '{1'b0, 4'h0, 16'h1000, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd4},
        '{1'b0, 4'h0, 16'h1000, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd4},
        '{1'b0, 4'h0, 16'h1000, 1'b1, 1'b1, 1'b1, 4'hC, 1'b0, 8'h00, 4'd4},
        '{1'b0, 4'h0, 16'h1000, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h7C, 4'd4},
        '{1'b0, 4'h0, 16'h1040, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h7C, 4'd12},
        '{1'b0, 4'h0, 16'h1040, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd12},
        '{1'b0, 4'h0, 16'h1041, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd12},
        '{1'b0, 4'h0, 16'h1041, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd12},
        '{1'b0, 4'h0, 16'h1041, 1'b0, 1'b1, 1'b1, 4'h0, 1'b0, 8'h00, 4'd12},
        // master auto end-of-interrupt with rotation: R6 R8 R9
        '{1'b1, 4'hC, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 4'd1},
        '{1'b0, 4'hC, 16'h002A, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h00, 4'd8},
        '{1'b0, 4'hC, 16'h002A, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd8},
        '{1'b0, 4'hC, 16'h002A, 1'b1, 1'b1, 1'b1, 4'h1, 1'b0, 8'h00, 4'd8},
        '{1'b0, 4'hC, 16'h002A, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h21, 4'd10},
        '{1'b0, 4'hC, 16'h002A, 1'b1, 1'b1, 1'b1, 4'h3, 1'b0, 8'h00, 4'd8},
        '{1'b0, 4'hC, 16'h002B, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h23, 4'd9},
        '{1'b0, 4'hC, 16'h002B, 1'b1, 1'b1, 1'b1, 4'h5, 1'b0, 8'h00, 4'd9},
        '{1'b0, 4'hC, 16'h002B, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h25, 4'd9},
        '{1'b0, 4'hC, 16'h002B, 1'b1, 1'b1, 1'b1, 4'h0, 1'b0, 8'h00, 4'd9},
        '{1'b0, 4'hC, 16'h002B, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h20, 4'd6},
        '{1'b0, 4'hC, 16'h002B, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd6},
        '{1'b0, 4'hC, 16'h002B, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd6},
        // slave auto end-of-interrupt, second slave line passed up again: R4 R8 R10
        '{1'b1, 4'hB, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 4'd1},
        '{1'b0, 4'hB, 16'h0500, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h00, 4'd4},
        '{1'b0, 4'hB, 16'h0500, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd4},
        '{1'b0, 4'hB, 16'h0500, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd4},
        '{1'b0, 4'hB, 16'h0500, 1'b1, 1'b1, 1'b1, 4'h8, 1'b0, 8'h00, 4'd4},
        '{1'b0, 4'hB, 16'h0500, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h78, 4'd10},
        '{1'b0, 4'hB, 16'h0500, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 4'd8},
        '{1'b0, 4'hB, 16'h0500, 1'b1, 1'b1, 1'b1, 4'hA, 1'b0, 8'h00, 4'd8},
        '{1'b0, 4'hB, 16'h0500, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 8'h7A, 4'd4}
    };

    task automatic check(input int tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL R%0d %s: got 0x%0h expected 0x%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            rst_n = !TBL[i].rst;
            {m_aeoi, m_rot, s_aeoi, s_rot} = TBL[i].cfg;
            req = TBL[i].req;
            ack = TBL[i].ack;
            #1;
            if (TBL[i].chk) begin
                check(TBL[i].tag, "irq", int'(irq), int'(TBL[i].irq));
                if (TBL[i].irq) check(TBL[i].tag, "num", int'(num), int'(TBL[i].num));
                if (TBL[i].vchk) check(TBL[i].tag, "vector", int'(vec), int'(TBL[i].vec));
            end
        end

        // Directed: base low bits ignored, reset drops a live request (R5, R1)
        @(negedge clk);
        rst_n = 1'b0; req = '0; ack = 1'b0;
        {m_aeoi, m_rot, s_aeoi, s_rot} = 4'h0;
        m_base = 8'hC7;
        @(negedge clk);
        rst_n = 1'b1; req = 16'h0001;
        @(negedge clk);
        @(negedge clk);
        #1;
        check(2, "irq", int'(irq), 1);
        check(2, "num", int'(num), 0);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        #1;
        check(5, "vector", int'(vec), 8'hC0);
        check(10, "irq", int'(irq), 0);
        req = 16'h0003;
        @(negedge clk);
        @(negedge clk);
        #1;
        check(7, "irq", int'(irq), 0); // line 1 blocked by line 0 in service
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check(1, "irq", int'(irq), 0);
        check(1, "vector", int'(vec), 0);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog expired: got running expected finished");
            summary();
            $finish;
        end
    end

endmodule